// File: doc/BRIEF.md
# Serial Command and Register Port for a Multichannel Converter

This block is the serial slave port of a multichannel data converter. A host drives chip select, serial clock and serial data in SPI mode 1 (clock idles low, data launched on the rising edge and captured on the falling edge). The port decodes single-byte commands and turns them into one-clock strobes for the conversion controller. It decodes two-byte register read and write commands that stream a burst of consecutive bytes out of, or into, a small byte-wide register file. It also shifts out a parallel conversion word, either on request or automatically after every conversion.

All serial inputs are sampled by the master clock and edges are found by comparing successive samples, so the serial clock must be several times slower than the master clock. The port also owns the data-ready flag. A finished conversion pulls that flag low, and the first falling serial-clock edge of the next transfer pulls it high again. After the command that leaves continuous readout, a short holdoff counted in master clocks makes the port ignore any byte that completes inside the window.

Top module: `spi_cmd_if`

## Requirements
- R1: `sdo` changes only one master clock after a detected rising `sclk` edge while `cs_n` is low, and bytes are shifted MSB first in both directions, with `din` captured on the falling edge.
- R2: `sdo_oe` is low in every clock that follows a clock in which `cs_n` was high.
- R3: The byte 001a_aaaa followed by 000n_nnnn streams n+1 register bytes starting at address a, one per following byte. Addresses at or above NREG read as 00h.
- R4: The byte 010a_aaaa followed by 000n_nnnn and n+1 data bytes writes those bytes to consecutive addresses starting at a. Writes to address 00h or to addresses at or above NREG are ignored, and address 00h always reads ID_VAL.
- R5: Each of the single-byte commands 08h (start), 0Ah (stop), 12h (read data), 10h (continuous on), 11h (continuous off) and 06h (reset) gives a one-clock pulse on its own strobe. Any other single byte gives no strobe, and no two strobes are high together.
- R6: The reset command clears every writable register to 00h on the eighth falling `sclk` edge of its byte. After seven edges the registers are unchanged.
- R7: `conv_done` drives `drdy_n` low. The first falling `sclk` edge after `cs_n` goes low drives it high, and `conv_done` wins when both fall in the same clock.
- R8: After the read-data command, the next FRAME_W bits on `sdo` are `frame_word` as sampled at the command's eighth falling edge.
- R9: While continuous readout is on, every `conv_done` loads `frame_word` for shifting out with no command. In that mode only the continuous-off command is honoured, and other command bytes give no strobe.
- R10: A byte that completes within HOLDOFF_CYC master clocks after an accepted continuous-off command is ignored. The same byte after the window is accepted.
- R11: Raising `cs_n` part way through a byte or a multi-byte command clears the bit count and the command state, so the first byte after `cs_n` falls again is decoded as a command.
- R12: After reset `drdy_n` is high, `sdo_oe` is low, all strobes are low, and all registers read 00h except address 00h, which reads ID_VAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| drdy_n | output | 1 | Data-ready flag, active low |
| conv_done | input | 1 | One-clock pulse when a conversion word is ready |
| frame_word | input | FRAME_W | Parallel conversion word for readout |
| cfg_regs | output | NREG*8 | Register file contents, address a at bits a*8+7..a*8 |
| cmd_start | output | 1 | Start-conversion strobe |
| cmd_stop | output | 1 | Stop-conversion strobe |
| cmd_reset | output | 1 | Reset-command strobe |
| cmd_rdata | output | 1 | Single read-data strobe |
| cmd_rdatac | output | 1 | Continuous-readout-on strobe |
| cmd_sdatac | output | 1 | Continuous-readout-off strobe |

## Verification
The bench builds the port with a 24-bit frame, so each conversion readout takes three bytes and the frame check stays short. The register count is 24, so a burst that crosses the top of the file reaches the out-of-range read path. The holdoff is raised to 100 master clocks. One serial byte takes 64 clocks, so a command sent straight after continuous-off completes inside the window and a later one completes outside it, which makes both sides of R10 reachable.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_RESET  = 8'h06;
  localparam logic [7:0] OP_START  = 8'h08;
  localparam logic [7:0] OP_STOP   = 8'h0A;
  localparam logic [7:0] OP_RDATAC = 8'h10;
  localparam logic [7:0] OP_SDATAC = 8'h11;
  localparam logic [7:0] OP_RDATA  = 8'h12;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_COUNT,
    ST_READ,
    ST_WRITE
  } dec_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic reset;
    logic rdata;
    logic rdatac;
    logic sdatac;
  } strobe_t;

  function automatic logic op_is_rreg(input logic [7:0] b);
    return b[7:5] == 3'b001;
  endfunction

  function automatic logic op_is_wreg(input logic [7:0] b);
    return b[7:5] == 3'b010;
  endfunction

  // Address 0 is the fixed identification byte; the rest below nreg are storage.
  function automatic logic reg_writable(input logic [4:0] a, input int nreg);
    return (a != 5'd0) && (int'(a) < nreg);
  endfunction

  function automatic logic [4:0] next_addr(input logic [4:0] a);
    return a + 5'd1;
  endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int FRAME_W = 216
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_data,
  output logic               cs_high,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic               first_fall,
  output logic               byte_done,
  output logic [7:0]         rx_byte,
  output logic               sdo,
  output logic               sdo_oe
);
  localparam int MSB = FRAME_W - 1;

  logic             cs_q, sclk_q, sclk_qq, din_q, started;
  logic [2:0]       bit_cnt;
  logic [6:0]       rx_sr;
  logic [MSB:0]     tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      din_q   <= din;
    end
  end

  assign cs_high    = cs_q;
  assign sclk_rise  = !cs_q && sclk_q && !sclk_qq;
  assign sclk_fall  = !cs_q && !sclk_q && sclk_qq;
  assign first_fall = sclk_fall && !started;
  assign byte_done  = sclk_fall && (bit_cnt == 3'd7);
  assign rx_byte    = {rx_sr, din_q};
  assign sdo_oe     = !cs_q;

  // receive side: falling-edge capture, count cleared whenever select is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      started <= 1'b0;
    end else if (cs_q) begin
      bit_cnt <= '0;
      started <= 1'b0;
    end else if (sclk_fall) begin
      rx_sr   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      started <= 1'b1;
    end
  end

  // transmit side: a load wins over a shift in the same clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (sclk_rise) begin
      tx_sr <= tx_sr << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
    end else if (cs_q) begin
      sdo <= 1'b0;
    end else if (sclk_rise) begin
      sdo <= tx_sr[MSB];
    end
  end

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int NREG        = 24,
  parameter int FRAME_W     = 216,
  parameter int HOLDOFF_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_high,
  input  logic               byte_done,
  input  logic [7:0]         rx_byte,
  input  logic               conv_done,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [7:0]         reg_rdata,
  output logic [4:0]         reg_raddr,
  output logic               reg_we,
  output logic [4:0]         reg_waddr,
  output logic [7:0]         reg_wdata,
  output logic               soft_reset,
  output strobe_t            strobes,
  output logic               tx_load,
  output logic [FRAME_W-1:0] tx_data,
  output logic               holdoff_busy
);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int PAD_W = FRAME_W - 8;

  dec_state_t state;
  logic [4:0] addr;
  logic [4:0] cnt;
  logic       is_wr;
  logic       rdatac_mode;
  logic [HW-1:0] hold_cnt;
  logic       accept;

  assign holdoff_busy = (hold_cnt != '0);
  assign accept       = byte_done && (state == ST_OPCODE) && !holdoff_busy;
  assign soft_reset   = accept && !rdatac_mode && (rx_byte == OP_RESET);

  assign reg_raddr = (state == ST_READ) ? next_addr(addr) : addr;
  assign reg_we    = byte_done && (state == ST_WRITE);
  assign reg_waddr = addr;
  assign reg_wdata = rx_byte;

  always_comb begin
    tx_load = 1'b0;
    tx_data = '0;
    if (byte_done && (state == ST_COUNT) && !is_wr) begin
      tx_load = 1'b1;
      tx_data = {reg_rdata, {PAD_W{1'b0}}};
    end else if (byte_done && (state == ST_READ) && (cnt != 5'd0)) begin
      tx_load = 1'b1;
      tx_data = {reg_rdata, {PAD_W{1'b0}}};
    end else if (accept && !rdatac_mode && (rx_byte == OP_RDATA)) begin
      tx_load = 1'b1;
      tx_data = frame_word;
    end else if (conv_done && rdatac_mode) begin
      tx_load = 1'b1;
      tx_data = frame_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPCODE;
      addr  <= '0;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else if (cs_high) begin
      state <= ST_OPCODE;
    end else if (byte_done) begin
      unique case (state)
        ST_OPCODE: begin
          if (accept && !rdatac_mode) begin
            if (op_is_rreg(rx_byte)) begin
              addr  <= rx_byte[4:0];
              is_wr <= 1'b0;
              state <= ST_COUNT;
            end else if (op_is_wreg(rx_byte)) begin
              addr  <= rx_byte[4:0];
              is_wr <= 1'b1;
              state <= ST_COUNT;
            end
          end
        end
        ST_COUNT: begin
          cnt   <= rx_byte[4:0];
          state <= is_wr ? ST_WRITE : ST_READ;
        end
        ST_READ, ST_WRITE: begin
          if (cnt == 5'd0) begin
            state <= ST_OPCODE;
          end else begin
            addr <= next_addr(addr);
            cnt  <= cnt - 5'd1;
          end
        end
        default: state <= ST_OPCODE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdatac_mode <= 1'b0;
      hold_cnt    <= '0;
      strobes     <= '0;
    end else begin
      strobes <= '0;
      if (holdoff_busy) hold_cnt <= hold_cnt - 1'b1;
      if (accept) begin
        if (rx_byte == OP_SDATAC) begin
          strobes.sdatac <= 1'b1;
          rdatac_mode    <= 1'b0;
          hold_cnt       <= HW'(HOLDOFF_CYC);
        end else if (!rdatac_mode) begin
          unique case (rx_byte)
            OP_START:  strobes.start <= 1'b1;
            OP_STOP:   strobes.stop  <= 1'b1;
            OP_RESET:  strobes.reset <= 1'b1;
            OP_RDATA:  strobes.rdata <= 1'b1;
            OP_RDATAC: begin
              strobes.rdatac <= 1'b1;
              rdatac_mode    <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import spi_cmd_pkg::*;
#(
  parameter int         NREG   = 24,
  parameter logic [7:0] ID_VAL = 8'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              we,
  input  logic [4:0]        waddr,
  input  logic [7:0]        wdata,
  input  logic [4:0]        raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] cfg_flat
);
  logic [7:0] regs [NREG];
  logic       we_ok;

  assign we_ok = we && reg_writable(waddr, NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_id
      assign regs[g] = ID_VAL;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          regs[g] <= '0;
        else if (soft_reset)                 regs[g] <= '0;
        else if (we_ok && waddr == 5'(g))    regs[g] <= wdata;
      end
    end
    assign cfg_flat[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (raddr == 5'(i)) rdata = regs[i];
    end
  end

endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
#(
  parameter int         NREG        = 24,
  parameter int         FRAME_W     = 216,
  parameter int         HOLDOFF_CYC = 4,
  parameter logic [7:0] ID_VAL      = 8'h3E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               drdy_n,
  input  logic               conv_done,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [NREG*8-1:0]  cfg_regs,
  output logic               cmd_start,
  output logic               cmd_stop,
  output logic               cmd_reset,
  output logic               cmd_rdata,
  output logic               cmd_rdatac,
  output logic               cmd_sdatac
);
  // named internal events, also observed by the bound checker
  logic               cs_high_w;
  logic               sclk_rise_w;
  logic               sclk_fall_w;
  logic               first_fall_w;
  logic               byte_done_w;
  logic [7:0]         rx_byte_w;
  logic               tx_load_w;
  logic [FRAME_W-1:0] tx_data_w;
  logic [4:0]         reg_raddr_w;
  logic [7:0]         reg_rdata_w;
  logic               reg_we_w;
  logic [4:0]         reg_waddr_w;
  logic [7:0]         reg_wdata_w;
  logic               soft_reset_w;
  logic               holdoff_busy_w;
  strobe_t            strobes_w;

  spi_bit_engine #(.FRAME_W(FRAME_W)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .din        (din),
    .load       (tx_load_w),
    .load_data  (tx_data_w),
    .cs_high    (cs_high_w),
    .sclk_rise  (sclk_rise_w),
    .sclk_fall  (sclk_fall_w),
    .first_fall (first_fall_w),
    .byte_done  (byte_done_w),
    .rx_byte    (rx_byte_w),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  cmd_decoder #(
    .NREG        (NREG),
    .FRAME_W     (FRAME_W),
    .HOLDOFF_CYC (HOLDOFF_CYC)
  ) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_high      (cs_high_w),
    .byte_done    (byte_done_w),
    .rx_byte      (rx_byte_w),
    .conv_done    (conv_done),
    .frame_word   (frame_word),
    .reg_rdata    (reg_rdata_w),
    .reg_raddr    (reg_raddr_w),
    .reg_we       (reg_we_w),
    .reg_waddr    (reg_waddr_w),
    .reg_wdata    (reg_wdata_w),
    .soft_reset   (soft_reset_w),
    .strobes      (strobes_w),
    .tx_load      (tx_load_w),
    .tx_data      (tx_data_w),
    .holdoff_busy (holdoff_busy_w)
  );

  reg_bank #(.NREG(NREG), .ID_VAL(ID_VAL)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_reset (soft_reset_w),
    .we         (reg_we_w),
    .waddr      (reg_waddr_w),
    .wdata      (reg_wdata_w),
    .raddr      (reg_raddr_w),
    .rdata      (reg_rdata_w),
    .cfg_flat   (cfg_regs)
  );

  // data-ready flag: a new word outranks the clearing edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            drdy_n <= 1'b1;
    else if (conv_done)    drdy_n <= 1'b0;
    else if (first_fall_w) drdy_n <= 1'b1;
  end

  assign cmd_start  = strobes_w.start;
  assign cmd_stop   = strobes_w.stop;
  assign cmd_reset  = strobes_w.reset;
  assign cmd_rdata  = strobes_w.rdata;
  assign cmd_rdatac = strobes_w.rdatac;
  assign cmd_sdatac = strobes_w.sdatac;

endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic drdy_n,
  input logic conv_done,
  input logic cmd_start,
  input logic cmd_stop,
  input logic cmd_reset,
  input logic cmd_rdata,
  input logic cmd_rdatac,
  input logic cmd_sdatac,
  input logic byte_done,
  input logic first_fall,
  input logic sclk_rise,
  input logic cs_high,
  input logic holdoff_busy,
  input logic reg_we
);
  logic [5:0] strb;
  assign strb = {cmd_start, cmd_stop, cmd_reset, cmd_rdata, cmd_rdatac, cmd_sdatac};

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !cs_high) |=> $stable(sdo));  // R1

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !sdo_oe);  // R2

  AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> byte_done);  // R4

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));  // R5

  AST_RESET_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> $past(byte_done));  // R6

  AST_DRDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (first_fall && !conv_done) |=> drdy_n);  // R7

  AST_DRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !drdy_n);  // R7

  AST_HOLDOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_busy && byte_done) |=> (strb == 6'b0));  // R10

endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sdo          (sdo),
  .sdo_oe       (sdo_oe),
  .drdy_n       (drdy_n),
  .conv_done    (conv_done),
  .cmd_start    (cmd_start),
  .cmd_stop     (cmd_stop),
  .cmd_reset    (cmd_reset),
  .cmd_rdata    (cmd_rdata),
  .cmd_rdatac   (cmd_rdatac),
  .cmd_sdatac   (cmd_sdatac),
  .byte_done    (byte_done_w),
  .first_fall   (first_fall_w),
  .sclk_rise    (sclk_rise_w),
  .cs_high      (cs_high_w),
  .holdoff_busy (holdoff_busy_w),
  .reg_we       (reg_we_w)
);

// File: tb/test_spi_cmd_if.sv
`timescale 1ns/1ps
module test_spi_cmd_if;
  localparam int         NREG    = 24;
  localparam int         FRAME_W = 24;
  localparam int         HOLD    = 100;
  localparam logic [7:0] ID      = 8'h3E;
  localparam int         HP      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic sdo, sdo_oe, drdy_n;
  logic conv_done = 1'b0;
  logic [FRAME_W-1:0] frame_word = '0;
  logic [NREG*8-1:0] cfg_regs;
  logic cmd_start, cmd_stop, cmd_reset, cmd_rdata, cmd_rdatac, cmd_sdatac;

  int n_checks = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_reset = 0, n_rdata = 0, n_rdatac = 0, n_sdatac = 0;
  logic [7:0] exp_regs [NREG];
  logic [7:0] rx;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_cmd_if #(.NREG(NREG), .FRAME_W(FRAME_W), .HOLDOFF_CYC(HOLD), .ID_VAL(ID)) i_spi_cmd_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sdo(sdo), .sdo_oe(sdo_oe), .drdy_n(drdy_n),
    .conv_done(conv_done), .frame_word(frame_word), .cfg_regs(cfg_regs),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_reset(cmd_reset),
    .cmd_rdata(cmd_rdata), .cmd_rdatac(cmd_rdatac), .cmd_sdatac(cmd_sdatac));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(input int a);
    return cfg_regs[a*8 +: 8];
  endfunction

  // per-clock comparison against the behavioural view of the port
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check(sdo_oe === !cs_n, "R2 sdo_oe vs cs_n", 64'(sdo_oe), 64'(!cs_n));
      check($countones({cmd_start, cmd_stop, cmd_reset, cmd_rdata, cmd_rdatac, cmd_sdatac}) <= 1,
            "R5 strobes one at a time", 64'({cmd_start, cmd_stop, cmd_reset, cmd_rdata, cmd_rdatac, cmd_sdatac}), 64'd0);
      n_start  += int'(cmd_start);
      n_stop   += int'(cmd_stop);
      n_reset  += int'(cmd_reset);
      n_rdata  += int'(cmd_rdata);
      n_rdatac += int'(cmd_rdatac);
      n_sdatac += int'(cmd_sdatac);
    end
  end

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_rel();
    cs_n = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int hi, input int lo, output logic [7:0] r);
    r = '0;
    for (int i = hi; i >= lo; i--) begin
      sclk = 1'b1;
      din  = tx[i];
      repeat (HP) @(negedge clk);
      r[i] = sdo;
      sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] r);
    spi_bits(tx, 7, 0, r);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_low();
    spi_byte(op, d);
    cs_rel();
  endtask

  task automatic wr_burst(input int a, input int n, input logic [7:0] base);
    logic [7:0] d;
    cs_low();
    spi_byte({3'b010, 5'(a)}, d);
    spi_byte({3'b000, 5'(n - 1)}, d);
    for (int i = 0; i < n; i++) begin
      spi_byte(base + 8'(i), d);
      if ((a + i) != 0 && (a + i) < NREG) exp_regs[a + i] = base + 8'(i);
    end
    cs_rel();
  endtask

  task automatic rd_burst(input int a, input int n);
    logic [7:0] d;
    cs_low();
    spi_byte({3'b001, 5'(a)}, d);
    spi_byte({3'b000, 5'(n - 1)}, d);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      spi_byte(8'h00, d);
      e = ((a + i) < NREG) ? exp_regs[a + i] : 8'h00;
      check(d === e, "R3 burst read byte", 64'(d), 64'(e));
    end
    cs_rel();
  endtask

  task automatic pulse_conv(input logic [FRAME_W-1:0] w);
    frame_word = w;
    conv_done  = 1'b1;
    @(negedge clk);
    conv_done  = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_frame(output logic [FRAME_W-1:0] f, input logic [7:0] din_byte);
    logic [7:0] d;
    for (int b = 0; b < FRAME_W / 8; b++) begin
      spi_byte(din_byte, d);
      f[FRAME_W-1-8*b -: 8] = d;
    end
  endtask

  initial begin
    logic [FRAME_W-1:0] f;
    int s0;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    exp_regs[0] = ID;

    repeat (3) @(negedge clk);
    // R12: state held in reset
    check(drdy_n === 1'b1, "R12 drdy_n in reset", 64'(drdy_n), 64'd1);
    check(sdo_oe === 1'b0, "R12 sdo_oe in reset", 64'(sdo_oe), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(reg_at(0) === ID, "R12 id register after reset", 64'(reg_at(0)), 64'(ID));
    check(reg_at(5) === 8'h00, "R12 register 05h after reset", 64'(reg_at(5)), 64'd0);
    check({cmd_start, cmd_stop, cmd_reset, cmd_rdata, cmd_rdatac, cmd_sdatac} === 6'b0,
          "R12 strobes after reset", 64'({cmd_start, cmd_stop, cmd_reset}), 64'd0);

    // R4: burst write across the channel block, then a single write to 17h
    wr_burst(5, 8, 8'hA0);
    for (int a = 5; a <= 12; a++)
      check(reg_at(a) === exp_regs[a], "R4 burst write", 64'(reg_at(a)), 64'(exp_regs[a]));
    wr_burst(23, 1, 8'h08);
    check(reg_at(23) === 8'h08, "R4 write 17h", 64'(reg_at(23)), 64'h08);
    wr_burst(0, 1, 8'h55);
    check(reg_at(0) === ID, "R4 id write ignored", 64'(reg_at(0)), 64'(ID));
    wr_burst(30, 1, 8'h77);
    check(reg_at(1) === 8'h00, "R4 out of range write ignored", 64'(reg_at(1)), 64'd0);

    // R3 / R1: burst reads, including the id byte and the top of the file
    rd_burst(10, 4);
    rd_burst(0, 1);
    rd_burst(22, 3);

    // R5: single-byte commands
    s0 = n_start;
    send_cmd(8'h08);
    check(n_start == s0 + 1, "R5 start strobe", 64'(n_start), 64'(s0 + 1));
    send_cmd(8'h0A);
    check(n_stop == 1, "R5 stop strobe", 64'(n_stop), 64'd1);
    send_cmd(8'h02);
    check(n_start + n_stop + n_reset + n_rdata + n_rdatac + n_sdatac == s0 + 2,
          "R5 unknown byte ignored", 64'(n_start + n_stop), 64'(s0 + 2));

    // R7 / R8: single readout
    pulse_conv(24'hC3_5A_96);
    check(drdy_n === 1'b0, "R7 drdy_n low after conv_done", 64'(drdy_n), 64'd0);
    frame_word = 24'h000000;
    frame_word = 24'hC3_5A_96;
    cs_low();
    spi_bits(8'h12, 7, 7, rx);
    check(drdy_n === 1'b1, "R7 drdy_n high after first fall", 64'(drdy_n), 64'd1);
    spi_bits(8'h12, 6, 0, rx);
    frame_word = 24'h111111;
    read_frame(f, 8'h00);
    cs_rel();
    check(f === 24'hC3_5A_96, "R8 read-data frame", 64'(f), 64'hC35A96);
    check(n_rdata == 1, "R5 read-data strobe", 64'(n_rdata), 64'd1);

    // R9: continuous readout
    send_cmd(8'h10);
    check(n_rdatac == 1, "R5 continuous-on strobe", 64'(n_rdatac), 64'd1);
    pulse_conv(24'h7E_81_3C);
    s0 = n_start;
    cs_low();
    read_frame(f, 8'h08);
    cs_rel();
    check(f === 24'h7E_81_3C, "R9 continuous frame", 64'(f), 64'h7E813C);
    check(n_start == s0, "R9 start ignored in continuous mode", 64'(n_start), 64'(s0));

    // R10: holdoff after continuous-off
    cs_low();
    spi_byte(8'h11, rx);
    spi_byte(8'h08, rx);
    cs_rel();
    check(n_sdatac == 1, "R5 continuous-off strobe", 64'(n_sdatac), 64'd1);
    check(n_start == s0, "R10 start inside holdoff ignored", 64'(n_start), 64'(s0));
    repeat (HOLD + 20) @(negedge clk);
    send_cmd(8'h08);
    check(n_start == s0 + 1, "R10 start after holdoff", 64'(n_start), 64'(s0 + 1));

    // R11: select released mid-byte and mid-command
    cs_low();
    spi_bits(8'hFF, 7, 4, rx);
    cs_rel();
    send_cmd(8'h08);
    check(n_start == s0 + 2, "R11 recovery after partial byte", 64'(n_start), 64'(s0 + 2));
    cs_low();
    spi_byte(8'h45, rx);
    cs_rel();
    send_cmd(8'h08);
    check(n_start == s0 + 3, "R11 recovery after partial command", 64'(n_start), 64'(s0 + 3));
    check(reg_at(5) === exp_regs[5], "R11 no stray write", 64'(reg_at(5)), 64'(exp_regs[5]));

    // R6: reset command lands on the eighth falling edge
    cs_low();
    spi_bits(8'h06, 7, 1, rx);
    check(reg_at(5) === exp_regs[5], "R6 registers kept after seven edges", 64'(reg_at(5)), 64'(exp_regs[5]));
    check(n_reset == 0, "R6 no reset strobe yet", 64'(n_reset), 64'd0);
    spi_bits(8'h06, 0, 0, rx);
    check(reg_at(5) === 8'h00, "R6 register 05h cleared", 64'(reg_at(5)), 64'd0);
    check(reg_at(23) === 8'h00, "R6 register 17h cleared", 64'(reg_at(23)), 64'd0);
    check(reg_at(0) === ID, "R6 id kept", 64'(reg_at(0)), 64'(ID));
    check(n_reset == 1, "R6 reset strobe", 64'(n_reset), 64'd1);
    cs_rel();
    for (int i = 1; i < NREG; i++) exp_regs[i] = 8'h00;
    rd_burst(4, 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule